// File: doc/BRIEF.md
# Oscillator Band Search Controller

This controller picks one of 24 oscillator bands for a frequency synthesizer. In automatic mode a start strobe loads a programmed band as the first candidate. On each candidate the controller waits a programmable number of settle ticks. It then samples a 3-bit code from the tuning-voltage converter and sorts that code into one of three classes: step the band down, step it up, or accept it. The search ends when a code shows the tuning voltage sitting in the narrow, drift-tolerant middle window. It also ends when the search cannot continue.

Two flags report progress. The idle flag is low only while a search runs. The success flag is high only after a search that ended on an accepted code. In manual mode the band is taken straight from the programmed value. Software can then let the converter result through to the reported code, or freeze it.

All pins are plain control and status signals, with no data stream. The settle tick is a qualifier that the surrounding logic supplies, and the block applies no back-pressure to it.

Top module: `vco_band_search`

## Requirements
- R1: Out of reset, band_o is 0, srch_idle_o is 1, srch_ok_o is 0 and code_o is 000.
- R2: With auto_en_i high, a start_i pulse with prog_band_i below 24 sets band_o to prog_band_i, drives srch_idle_o to 0 and clears srch_ok_o, all on the clock edge that samples the strobe.
- R3: After a search starts and after each band change, the code is not sampled until settle_len_i settle_tick_i pulses have been counted; a value of 0 samples on the next cycle.
- R4: A sampled code of 010 or 101 ends the search with success: srch_idle_o=1, srch_ok_o=1, band_o keeps the accepted band and code_o shows the sampled code.
- R5: Codes 000, 001 and 011 move the band down by one, and codes 110, 111 and 100 move it up by one. While a search runs, band_o stays below 24.
- R6: A step that would leave the range 0..23 ends the search with failure: srch_idle_o=1, srch_ok_o=0, and band_o stays at the edge band.
- R7: If 24 codes have been sampled in one search without an accepted code, the search ends with failure, and band_o keeps the band of the 24th sample.
- R8: A start_i pulse during a search restarts the search from the current prog_band_i.
- R9: A start_i pulse in automatic mode with prog_band_i of 24 or more ends at once with failure: srch_idle_o=1, srch_ok_o=0, band_o unchanged.
- R10: With auto_en_i low, band_o equals prog_band_i one cycle later, srch_idle_o=1, srch_ok_o=0, and start_i has no effect.
- R11: With auto_en_i low, code_o takes adc_code_i on each clock edge where adc_en_i=1 and adc_latch_i=0, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Tuning-start strobe |
| auto_en_i | input | 1 | 1 = automatic band search, 0 = manual band |
| adc_en_i | input | 1 | Manual mode: let the converter code through |
| adc_latch_i | input | 1 | Manual mode: freeze the reported code |
| prog_band_i | input | 5 | Programmed band (manual value or search start) |
| settle_len_i | input | 8 | Settle ticks to wait before each sample |
| settle_tick_i | input | 1 | Settle time-base pulse |
| adc_code_i | input | 3 | Tuning-voltage converter code |
| band_o | output | 5 | Selected band |
| srch_idle_o | output | 1 | 0 while a search is running |
| srch_ok_o | output | 1 | 1 after a successful search |
| code_o | output | 3 | Reported converter code |

## Verification
The bench drives the converter code from a model that compares band_o with a target band, so searches run up, run down, or start on the target. It pushes targets beyond both ends of the range. A design that wraps the index or forgets the edge check would report a bogus band, or success with a band that does not exist. A two-band trap that flips the code back and forth exercises the 24-sample limit; without that limit the search never ends. Other tests restart a search that is slowed by long settling, start with an out-of-range band, and drive the manual latch. These catch a design that keeps the old start band, samples before settling, or lets the code leak through the latch.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    V_DOWN = 2'd0,
    V_UP   = 2'd1,
    V_HIT  = 2'd2
  } verdict_t;
endpackage

// File: rtl/vsel_classify.sv
module vsel_classify
  import vsel_pkg::*;
(
  input  logic [2:0] code_i,
  output verdict_t   verdict_o
);
  always_comb begin
    unique case (code_i)
      3'b010, 3'b101: verdict_o = V_HIT;
      3'b000, 3'b001, 3'b011: verdict_o = V_DOWN;
      default: verdict_o = V_UP;
    endcase
  end
endmodule

// File: rtl/vsel_settle_timer.sv
module vsel_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (restart_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q < limit_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign done_o = (cnt_q >= limit_i);
endmodule

// File: rtl/vsel_code_hold.sv
module vsel_code_hold #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_o <= '0;
    else if (load_i) code_o <= code_i;
  end
endmodule

// File: rtl/vco_band_search.sv
module vco_band_search
  import vsel_pkg::*;
#(
  parameter int NUM_BANDS = 24,
  parameter int BAND_W    = 5,
  parameter int CODE_W    = 3,
  parameter int SETTLE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                auto_en_i,
  input  logic                adc_en_i,
  input  logic                adc_latch_i,
  input  logic [BAND_W-1:0]   prog_band_i,
  input  logic [SETTLE_W-1:0] settle_len_i,
  input  logic                settle_tick_i,
  input  logic [CODE_W-1:0]   adc_code_i,
  output logic [BAND_W-1:0]   band_o,
  output logic                srch_idle_o,
  output logic                srch_ok_o,
  output logic [CODE_W-1:0]   code_o
);
  localparam int TRY_W = $clog2(NUM_BANDS + 1);
  localparam logic [TRY_W-1:0]  LAST_TRY = TRY_W'(NUM_BANDS - 1);
  localparam logic [BAND_W-1:0] TOP_BAND = BAND_W'(NUM_BANDS - 1);

  logic              searching_q;
  logic              ok_q;
  logic [BAND_W-1:0] band_q;
  logic [TRY_W-1:0]  tries_q;
  logic              settle_done;
  logic              sample_now;
  logic              prog_valid;
  logic              timer_restart;
  logic              code_load;
  verdict_t          verdict;

  assign prog_valid    = (32'(prog_band_i) < NUM_BANDS);
  assign sample_now    = auto_en_i && searching_q && settle_done && !start_i;
  assign timer_restart = !auto_en_i || start_i || sample_now;
  assign code_load     = auto_en_i ? sample_now : (adc_en_i && !adc_latch_i);

  vsel_classify u_class (
    .code_i    (adc_code_i[2:0]),
    .verdict_o (verdict)
  );

  vsel_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (timer_restart),
    .tick_i    (settle_tick_i),
    .limit_i   (settle_len_i),
    .done_o    (settle_done)
  );

  vsel_code_hold #(.CODE_W(CODE_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (code_load),
    .code_i (adc_code_i),
    .code_o (code_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      searching_q <= 1'b0;
      ok_q        <= 1'b0;
      band_q      <= '0;
      tries_q     <= '0;
    end else if (!auto_en_i) begin
      searching_q <= 1'b0;
      ok_q        <= 1'b0;
      band_q      <= prog_band_i;
      tries_q     <= '0;
    end else if (start_i) begin
      ok_q    <= 1'b0;
      tries_q <= '0;
      if (prog_valid) begin
        searching_q <= 1'b1;
        band_q      <= prog_band_i;
      end else begin
        searching_q <= 1'b0;
      end
    end else if (sample_now) begin
      tries_q <= tries_q + TRY_W'(1);
      unique case (verdict)
        V_HIT: begin
          searching_q <= 1'b0;
          ok_q        <= 1'b1;
        end
        V_DOWN: begin
          if (band_q == '0 || tries_q == LAST_TRY) searching_q <= 1'b0;
          else band_q <= band_q - BAND_W'(1);
        end
        default: begin
          if (band_q == TOP_BAND || tries_q == LAST_TRY) searching_q <= 1'b0;
          else band_q <= band_q + BAND_W'(1);
        end
      endcase
    end
  end

  assign band_o      = band_q;
  assign srch_idle_o = !searching_q;
  assign srch_ok_o   = ok_q;
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
  parameter int NUM_BANDS = 24,
  parameter int BAND_W    = 5,
  parameter int CODE_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              auto_en_i,
  input logic              adc_latch_i,
  input logic [BAND_W-1:0] prog_band_i,
  input logic [BAND_W-1:0] band_o,
  input logic              srch_idle_o,
  input logic              srch_ok_o,
  input logic [CODE_W-1:0] code_o
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && start_i && auto_en_i && 32'(prog_band_i) < NUM_BANDS)
      |=> (!srch_idle_o && !srch_ok_o && band_o == $past(prog_band_i)));

  a_r4_ok_means_done_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    srch_ok_o |-> (srch_idle_o && (code_o == 3'b010 || code_o == 3'b101)));

  a_r5_band_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_idle_o |-> (32'(band_o) < NUM_BANDS));

  a_r9_bad_start_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && start_i && auto_en_i && 32'(prog_band_i) >= NUM_BANDS)
      |=> (srch_idle_o && !srch_ok_o && $stable(band_o)));

  a_r10_manual_band: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !auto_en_i)
      |=> (band_o == $past(prog_band_i) && srch_idle_o && !srch_ok_o));

  a_r11_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !auto_en_i && adc_latch_i) |=> $stable(code_o));
endmodule

bind vco_band_search vsel_checker #(
  .NUM_BANDS(NUM_BANDS), .BAND_W(BAND_W), .CODE_W(CODE_W)
) u_vsel_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .auto_en_i   (auto_en_i),
  .adc_latch_i (adc_latch_i),
  .prog_band_i (prog_band_i),
  .band_o      (band_o),
  .srch_idle_o (srch_idle_o),
  .srch_ok_o   (srch_ok_o),
  .code_o      (code_o)
);

// File: tb/tb_vco_band_search.sv
`timescale 1ns/1ps
module tb_vco_band_search;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       auto_en = 1'b0;
  logic       adc_en = 1'b0;
  logic       adc_latch = 1'b0;
  logic [4:0] prog_band = '0;
  logic [7:0] settle_len = 8'd2;
  logic       settle_tick = 1'b0;
  logic [2:0] adc_code;
  logic [4:0] band;
  logic       idle, ok;
  logic [2:0] code;

  int  tgt = 0;
  bit  osc_en = 0;
  int  osc_hi = 0;
  bit  ovr_en = 0;
  logic [2:0] ovr_val = '0;

  int checks = 0;
  int failures = 0;
  bit ended = 0;

  typedef struct { int band; bit ok; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  vco_band_search dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .auto_en_i(auto_en),
    .adc_en_i(adc_en), .adc_latch_i(adc_latch), .prog_band_i(prog_band),
    .settle_len_i(settle_len), .settle_tick_i(settle_tick), .adc_code_i(adc_code),
    .band_o(band), .srch_idle_o(idle), .srch_ok_o(ok), .code_o(code)
  );

  // Tuning-voltage model: code depends on distance of band from target
  always_comb begin
    int d;
    d = int'(band) - tgt;
    if (ovr_en)                              adc_code = ovr_val;
    else if (osc_en && int'(band) == osc_hi)     adc_code = 3'b001;
    else if (osc_en && int'(band) == osc_hi - 1) adc_code = 3'b110;
    else if (d <= -2)                        adc_code = 3'b111;
    else if (d == -1)                        adc_code = 3'b110;
    else if (d == 0)                         adc_code = (tgt % 2 != 0) ? 3'b101 : 3'b010;
    else if (d == 1)                         adc_code = 3'b001;
    else                                     adc_code = 3'b000;
  end

  initial begin
    forever begin
      repeat (3) @(posedge clk);
      #1 settle_tick = 1'b1;
      @(posedge clk);
      #1 settle_tick = 1'b0;
    end
  end

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic push(input int b, input bit k, input string tag);
    exp_t e;
    e.band = b; e.ok = k; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic run_search(input int pb, input int t, input int eb, input bit ek,
                            input string tag);
    tgt = t;
    prog_band = 5'(pb);
    push(eb, ek, tag);
    pulse_start();
    check("R2 start band", int'(band), pb);
    check("R2 idle low", int'(idle), 0);
    wait_done();
  endtask

  task automatic wait_done();
    for (int n = 0; n < 5000 && sb_q.size() != 0; n++) step();
  endtask

  // Monitor: pop the expected result when a search finishes
  initial begin
    bit prev = 1'b1;
    forever begin
      step();
      if (rst_n && idle && !prev && sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " band"}, int'(band), e.band);
        check({e.tag, " ok"}, int'(ok), int'(e.ok));
        if (e.ok) check("R4 code is hit", int'(code == 3'b010 || code == 3'b101), 1);
      end
      prev = idle;
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    step();
    step();
    // R1 reset state
    check("R1 band", int'(band), 0);
    check("R1 idle", int'(idle), 1);
    check("R1 ok", int'(ok), 0);
    check("R1 code", int'(code), 0);
    rst_n = 1'b1;
    step();

    // R10 manual band
    prog_band = 5'd7;
    step();
    check("R10 manual band", int'(band), 7);
    pulse_start();
    check("R10 start ignored idle", int'(idle), 1);
    check("R10 start ignored ok", int'(ok), 0);
    check("R10 band kept", int'(band), 7);

    // R11 manual code reporting
    ovr_en = 1; ovr_val = 3'd5; adc_en = 1;
    step();
    check("R11 code loads", int'(code), 5);
    adc_latch = 1; ovr_val = 3'd2;
    step(); step();
    check("R11 latch holds", int'(code), 5);
    adc_latch = 0; adc_en = 0;
    step();
    check("R11 disabled holds", int'(code), 5);
    adc_en = 1;
    step();
    check("R11 reload", int'(code), 2);
    adc_en = 0; ovr_en = 0;

    // automatic searches
    auto_en = 1;
    step();
    run_search(3, 10, 10, 1, "R5 up search");
    settle_len = 8'd0;
    run_search(20, 5, 5, 1, "R5 down search");
    settle_len = 8'd2;
    run_search(12, 12, 12, 1, "R4 first hit");
    check("R4 code shows 010", int'(code), 2);
    run_search(6, 11, 11, 1, "R4 odd hit");
    check("R4 code shows 101", int'(code), 5);

    // R9 invalid programmed band
    prog_band = 5'd27;
    pulse_start();
    check("R9 idle", int'(idle), 1);
    check("R9 ok", int'(ok), 0);
    check("R9 band unchanged", int'(band), 11);

    // R6 boundary failures
    run_search(18, 40, 23, 0, "R6 top edge");
    run_search(4, -5, 0, 0, "R6 bottom edge");

    // R7 oscillation trap
    osc_en = 1; osc_hi = 9;
    run_search(9, 9, 8, 0, "R7 try limit");
    osc_en = 0;

    // R3 settle and R8 restart
    settle_len = 8'd4;
    tgt = 20;
    prog_band = 5'd2;
    push(20, 1, "R8 restart result");
    pulse_start();
    check("R2 band on start", int'(band), 2);
    repeat (10) step();
    check("R3 no sample before settle", int'(band), 2);
    prog_band = 5'd15;
    pulse_start();
    check("R8 restart band", int'(band), 15);
    check("R8 still searching", int'(idle), 0);
    wait_done();
    check("R8 queue drained", sb_q.size(), 0);

    repeat (3) step();
    finish_run();
  end
endmodule